// File: doc/BRIEF.md
# Phase-Threshold Loss-of-Lock Detector

This block watches two already-divided clocks, a reference and the feedback copy of a phase-locked loop's oscillator, from a faster sampling clock. Each clock is brought into the sampling domain by its own two-flop synchronizer. The exclusive-OR of the two synchronized bits is the raw phase error. It is high for a share of each compare period equal to the phase offset, so 180 degrees keeps it high all the time.

The error bit feeds a first-order recursive averager whose corner is set by a right-shift amount. The averaged level is compared with a phase threshold given as a code. While the level is above the threshold the lock flag is held low. To flag a frequency offset reliably, software sets the shift so that the corner sits roughly a decade below the expected beat frequency. Otherwise the averaged level would sag below the threshold during the in-phase part of each beat. After reset the averager starts at full scale, so the flag reads unlocked until a clean error history has pulled the level down.

Top module: `lock_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, the lock flag is low and the averaged level is full scale (2^ACC_W-1). The flag then stays low until the level has fallen to the threshold or below.
- R2: The raw error is the XOR of the two synchronized clocks. Inputs that stay equal drive the level to zero and raise the lock flag.
- R3: A nonzero threshold code c maps to level c·2^(ACC_W-THR_W), so code 2^THR_W-1 is just under 180 degrees. The lock flag is low exactly when the level is strictly greater than that value.
- R4: Threshold code 0 selects the default of one quarter of full scale, 2^(ACC_W-2), which is 45 degrees.
- R5: Each cycle the level y becomes y + ((x - y) >>> k), using a signed arithmetic shift. Here x is 2^ACC_W-1 when the error bit is high and 0 otherwise, and k is the shift input. With k = 0 the level equals x at once.
- R6: A change on the clock inputs reaches the lock flag after four sampling edges: two synchronizer stages, the averager and the flag register.
- R7: For a periodic error of steady duty cycle, the lock flag is high when the duty is well below the threshold fraction and low when it is well above.
- R8: Starting from level 0 with a constant error, the flag falls on the edge after the n-th averager update, where n is the first update whose level exceeds the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_clk_i | input | 1 | Divided reference clock, asynchronous |
| fb_clk_i | input | 1 | Divided feedback clock, asynchronous |
| thr_code_i | input | THR_W | Phase threshold code; 0 selects the quarter-scale default |
| shift_i | input | SHIFT_W | Averager shift k; a larger value gives a lower corner |
| lock_o | output | 1 | High when locked, low when the averaged error exceeds the threshold |

## Verification
The bench builds the block with its default parameters: a 16-bit level, an 8-bit threshold code and a 4-bit shift. The 8-bit code makes the exact threshold boundary visible, from about 15 % up to just under full scale. The 4-bit shift allows both k = 0, where the level follows the error bit in one cycle and the four-edge latency can be counted exactly, and slow corners where a 25 % or 75 % duty cycle averages with small ripple. With a 16-bit level, the update count for a step response stays short enough that the bench can predict the exact edge on which the flag falls.

// File: rtl/lol_pkg.sv
package lol_pkg;

  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_state_e;

  // one quarter of a 2^w full scale: the 45 degree default threshold
  function automatic int quarter_of(input int w);
    return 1 << (w - 2);
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/phase_err_filter.sv
module phase_err_filter #(
  parameter int ACC_W   = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               err_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [ACC_W-1:0]   level_o
);
  localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

  function automatic logic [ACC_W-1:0] iir_step(
    input logic [ACC_W-1:0]   y,
    input logic               x,
    input logic [SHIFT_W-1:0] k
  );
    logic [ACC_W-1:0]     tgt;
    logic signed [ACC_W:0] diff;
    logic signed [ACC_W:0] inc;
    logic signed [ACC_W:0] sum;
    tgt  = x ? FULL : '0;
    diff = $signed({1'b0, tgt}) - $signed({1'b0, y});
    inc  = diff >>> k;
    sum  = $signed({1'b0, y}) + inc;
    return ACC_W'(sum);
  endfunction

  logic [ACC_W-1:0] level_nxt;
  assign level_nxt = iir_step(level_o, err_i, shift_i);

  always_ff @(posedge clk) begin
    if (rst) level_o <= FULL;
    else     level_o <= level_nxt;
  end

  // R5: the level only climbs after an error sample
  p_rise_on_err_r5: assert property (@(posedge clk) disable iff (rst)
    (level_o > $past(level_o)) |-> $past(err_i));

  // R5: the level only drops after a clean sample
  p_fall_on_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (level_o < $past(level_o)) |-> !$past(err_i));

  // R5: with zero shift the level copies the error sample
  p_k0_follow_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(shift_i) == '0 && !$past(rst)) |->
      (level_o == ($past(err_i) ? FULL : '0)));
endmodule

// File: rtl/lock_compare.sv
module lock_compare
  import lol_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] level_i,
  input  logic [THR_W-1:0] thr_code_i,
  output logic [ACC_W-1:0] thr_level_o,
  output logic             lock_o
);
  localparam int SCALE = ACC_W - THR_W;
  localparam logic [ACC_W-1:0] QUARTER = ACC_W'(quarter_of(ACC_W));

  function automatic logic [ACC_W-1:0] thr_to_level(input logic [THR_W-1:0] code);
    if (code == '0) return QUARTER;
    return ACC_W'(code) << SCALE;
  endfunction

  lock_state_e state_q;

  assign thr_level_o = thr_to_level(thr_code_i);

  always_ff @(posedge clk) begin
    if (rst)                        state_q <= ST_UNLOCKED;
    else if (level_i > thr_level_o) state_q <= ST_UNLOCKED;
    else                            state_q <= ST_LOCKED;
  end

  assign lock_o = (state_q == ST_LOCKED);
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int ACC_W   = 16,
  parameter int THR_W   = 8,
  parameter int SHIFT_W = 4,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_clk_i,
  input  logic               fb_clk_i,
  input  logic [THR_W-1:0]   thr_code_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               lock_o
);
  localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

  logic [1:0]       raw_clk;
  logic [1:0]       syn_clk;
  logic             phase_err;
  logic [ACC_W-1:0] avg_level;
  logic [ACC_W-1:0] thr_level;

  assign raw_clk = {fb_clk_i, ref_clk_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    bit_sync #(.STAGES(SYNC_N)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw_clk[g]),
      .q_o (syn_clk[g])
    );
  end

  assign phase_err = syn_clk[0] ^ syn_clk[1];

  phase_err_filter #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .err_i   (phase_err),
    .shift_i (shift_i),
    .level_o (avg_level)
  );

  lock_compare #(.ACC_W(ACC_W), .THR_W(THR_W)) u_cmp (
    .clk         (clk),
    .rst         (rst),
    .level_i     (avg_level),
    .thr_code_i  (thr_code_i),
    .thr_level_o (thr_level),
    .lock_o      (lock_o)
  );

  // R1: the cycle after a reset cycle shows full scale and no lock
  p_reset_full_r1: assert property (@(posedge clk)
    $past(rst) |-> (avg_level == FULL && !lock_o));

  // R1: lock is only gained after the level fell to the threshold
  p_rise_needs_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(avg_level <= thr_level));

  // R3: a level above the threshold drops the flag on the next edge
  p_above_unlocks_r3: assert property (@(posedge clk) disable iff (rst)
    $past(avg_level > thr_level) |-> !lock_o);
endmodule

// File: tb/tb_lock_monitor.sv
module tb_lock_monitor;
  localparam int ACC_W = 16;
  localparam int THR_W = 8;
  localparam int SHIFT_W = 4;
  localparam int FULLV = (1 << ACC_W) - 1;
  localparam int NVEC = 9;

  // {ref pattern[4], fb pattern[4], thr code[8], shift[4], expected lock[1]}
  localparam logic [20:0] VEC [NVEC] = '{
    {4'b1010, 4'b1010, 8'd0,   4'd4, 1'b1},  // R2 equal clocks
    {4'b1100, 4'b1100, 8'd200, 4'd4, 1'b1},  // R2
    {4'b1111, 4'b0000, 8'd255, 4'd4, 1'b0},  // R3 full error above top code
    {4'b1100, 4'b0110, 8'd0,   4'd4, 1'b0},  // R4 50 % over 45 deg default
    {4'b1000, 4'b0000, 8'd128, 4'd4, 1'b1},  // R7 25 % under 50 %
    {4'b1110, 4'b0000, 8'd128, 4'd4, 1'b0},  // R7 75 % over 50 %
    {4'b1000, 4'b0000, 8'd40,  4'd4, 1'b0},  // R3 25 % over 15.6 %
    {4'b1000, 4'b0000, 8'd96,  4'd6, 1'b1},  // R7 25 % under 37.5 %
    {4'b1100, 4'b0000, 8'd96,  4'd6, 1'b0}   // R7 50 % over 37.5 %
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_clk = 1'b0;
  logic fb_clk = 1'b0;
  logic [THR_W-1:0] thr_code = '0;
  logic [SHIFT_W-1:0] shift = 4'd4;
  logic lock;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lock_monitor #(.ACC_W(ACC_W), .THR_W(THR_W), .SHIFT_W(SHIFT_W)) dut (
    .clk        (clk),
    .rst        (rst),
    .ref_clk_i  (ref_clk),
    .fb_clk_i   (fb_clk),
    .thr_code_i (thr_code),
    .shift_i    (shift),
    .lock_o     (lock)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s lock=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic run_pattern(input logic [3:0] rp, input logic [3:0] fp, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      ref_clk = rp[3 - (i % 4)];
      fb_clk  = fp[3 - (i % 4)];
      step(1);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int y;
    int n;
    // R1: reset holds the flag low
    step(4);
    check("R1 during reset", lock, 1'b0);
    rst = 1'b0;
    step(5);
    check("R1 level still high after reset", lock, 1'b0);
    step(300);
    check("R2 equal clocks lock", lock, 1'b1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      thr_code = VEC[v][12:5];
      shift    = VEC[v][4:1];
      run_pattern(VEC[v][20:17], VEC[v][16:13], 800);
      check($sformatf("R7 vector %0d", v), lock, VEC[v][0]);
    end

    // R6 / R5: latency with zero shift
    shift = '0; thr_code = '0;
    ref_clk = 1'b0; fb_clk = 1'b0;
    step(20);
    check("R5 k0 clean", lock, 1'b1);
    ref_clk = 1'b1;
    step(3);
    check("R6 not yet unlocked", lock, 1'b1);
    step(1);
    check("R6 unlocked on fourth edge", lock, 1'b0);
    fb_clk = 1'b1;
    step(3);
    check("R6 not yet relocked", lock, 1'b0);
    step(1);
    check("R6 relocked on fourth edge", lock, 1'b1);

    // R8: step response with shift 3 against half scale
    shift = 4'd3; thr_code = 8'd128;
    ref_clk = 1'b0; fb_clk = 1'b0;
    step(600);
    y = 0; n = 0;
    while (y <= (128 << (ACC_W - THR_W))) begin
      y = y + (FULLV - y) / 8;
      n++;
    end
    ref_clk = 1'b1;
    step(2 + n);
    check("R8 still locked before crossing", lock, 1'b1);
    step(1);
    check("R8 unlocked after crossing", lock, 1'b0);

    // R1: a second reset restores full scale
    ref_clk = 1'b0; shift = 4'd4; thr_code = '0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(4);
    check("R1 unlocked after re-reset", lock, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule